// File: doc/BRIEF.md
# Multi-Width Serial SRAM Slave Interface

This block is the target side of a serial SRAM. A host selects it with an active-low chip select, toggles a serial clock and moves command, address and data over one, two or four data lines. The framing is the same at every width: an 8-bit command code, a 24-bit byte address and then payload bytes, all most significant bit first. Each byte is cut into groups whose size equals the bus width, and the high group goes first. A write command fills an internal byte array. The address advances one byte at a time. A read-mode command streams back the mode register byte.

The block runs from a system clock `clk_i` that is several times faster than the serial clock. `sck_i`, `cs_ni` and `sio_i` must be synchronous to `clk_i`. Input groups are taken on rising serial-clock edges and output groups change on falling edges. The bus width comes from `width_i`, which stands in for the width field of the mode register. It is captured while the chip select is high and held for the rest of the transaction. Port `peek_addr_i`/`peek_data_o` is a second, read-only port of the byte array so that stored contents can be observed.

Top module: `ssram_slave`

## Requirements
- R1: While reset is applied, and on the clock after `cs_ni` is seen high, `sio_oe_o` is 4'b0000.
- R2: Command 8'h02 starts a write. In single width, each serial clock carries one bit on `sio_i[0]`. After the 24-bit address (MSB first), each full 8 bits are stored as one byte at the current address.
- R3: In dual width (`width_i` = 2'b01), each clock carries two bits on `sio_i[1:0]`, with `sio_i[1]` the more significant. A command takes 4 clocks, an address 12 clocks and a byte 4 clocks.
- R4: In quad width (`width_i[1]` = 1), each clock carries a nibble on `sio_i[3:0]`, with `sio_i[3]` the most significant. A command takes 2 clocks, an address 6 clocks and a byte 2 clocks (high nibble first).
- R5: The array is indexed by the low MEM_AW address bits and the higher bits are ignored. The address rises by one after every stored byte and wraps from the top location to 0.
- R6: If `cs_ni` rises before a byte is complete, those partial bits are dropped and no location changes.
- R7: After command 8'h05, the mode byte is driven MSB first from the first falling clock edge after the last command clock. In single width it uses `sio_o[1]` with `sio_oe_o` = 4'b0010. In dual width it uses `sio_o[1:0]` with 4'b0011. In quad width it uses `sio_o[3:0]` with 4'b1111.
- R8: `sio_oe_o` stays 4'b0000 while a command is being received and for the whole of any write or ignored transaction.
- R9: The mode byte is {2'b01 (sequential mode), 4'b0000, width code}.
- R10: The width is captured while `cs_ni` is high. A change of `width_i` during a selected transaction has no effect on it.
- R11: Any command other than 8'h02 or 8'h05 is ignored until `cs_ni` rises: nothing is written and nothing is driven.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, faster than the serial clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Active-low chip select |
| sck_i | input | 1 | Serial clock, idle low |
| sio_i | input | 4 | Serial data lines, input side |
| sio_o | output | 4 | Serial data lines, output side |
| sio_oe_o | output | 4 | Output enable for each data line |
| width_i | input | 2 | Bus width code: 00 single, 01 dual, 1x quad |
| peek_addr_i | input | MEM_AW | Observation read address into the byte array |
| peek_data_o | output | 8 | Byte stored at `peek_addr_i` |

## Verification
The bench builds the block with MEM_AW = 8, which gives a 256-byte array. With this size a short write that starts at an address whose low byte is 8'hFF crosses the top of the array. The address used has non-zero upper bits, so the test also shows that bits above the array index are discarded. The same transaction framing is sent at all three widths, and the 2'b11 code is also tried. The partial-byte and unknown-command cases are aimed at locations that hold known data from earlier writes.

// File: rtl/ssram_pkg.sv
package ssram_pkg;

  localparam logic [7:0] OP_WRITE  = 8'h02;
  localparam logic [7:0] OP_RDMODE = 8'h05;
  localparam logic [1:0] MODE_SEQ  = 2'b01;

  typedef enum logic [2:0] {
    ST_CMD,
    ST_ADDR,
    ST_DATA,
    ST_MODE,
    ST_SKIP
  } phase_e;

  // bits moved per serial clock for a width code
  function automatic logic [2:0] lane_step(input logic [1:0] code);
    if (code[1])      return 3'd4;
    else if (code[0]) return 3'd2;
    else              return 3'd1;
  endfunction

endpackage

// File: rtl/ssram_sck_edge.sv
module ssram_sck_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  output logic rise_o,
  output logic fall_o
);

  logic sck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_q <= 1'b0;
    else         sck_q <= sck_i;
  end

  assign rise_o = sck_i & ~sck_q;
  assign fall_o = ~sck_i & sck_q;

endmodule

// File: rtl/ssram_deser.sv
module ssram_deser (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       rise_i,
  input  logic [2:0] step_i,
  input  logic [3:0] sio_i,
  output logic       byte_vld_o,
  output logic [7:0] byte_o
);

  logic [7:0] acc_q, acc_nxt;
  logic [3:0] cnt_q, cnt_nxt;

  always_comb begin
    unique case (step_i)
      3'd4:    acc_nxt = {acc_q[3:0], sio_i};
      3'd2:    acc_nxt = {acc_q[5:0], sio_i[1:0]};
      default: acc_nxt = {acc_q[6:0], sio_i[0]};
    endcase
    cnt_nxt = cnt_q + {1'b0, step_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q      <= '0;
      cnt_q      <= '0;
      byte_vld_o <= 1'b0;
      byte_o     <= '0;
    end else if (clr_i) begin
      cnt_q      <= '0;
      byte_vld_o <= 1'b0;
    end else begin
      byte_vld_o <= 1'b0;
      if (rise_i) begin
        acc_q <= acc_nxt;
        if (cnt_nxt == 4'd8) begin
          cnt_q      <= '0;
          byte_vld_o <= 1'b1;
          byte_o     <= acc_nxt;
        end else begin
          cnt_q <= cnt_nxt;
        end
      end
    end
  end

  a_r2_group_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < 4'd8);

  a_r6_no_byte_after_deselect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !byte_vld_o);

endmodule

// File: rtl/ssram_mode_tx.sv
module ssram_mode_tx (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       en_i,
  input  logic       fall_i,
  input  logic [2:0] step_i,
  input  logic [7:0] mode_i,
  output logic [3:0] sio_o,
  output logic [3:0] sio_oe_o
);

  logic       act_q;
  logic [7:0] sh_q, src;
  logic [3:0] left_q, left_base;
  logic [3:0] grp_q, grp_nxt;
  logic       reload;

  assign reload    = !act_q || (left_q == 4'd0);
  assign src       = reload ? mode_i : sh_q;
  assign left_base = reload ? 4'd8 : left_q;

  always_comb begin
    unique case (step_i)
      3'd4:    grp_nxt = src[7:4];
      3'd2:    grp_nxt = {2'b00, src[7:6]};
      default: grp_nxt = {3'b000, src[7]};
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      sh_q   <= '0;
      left_q <= '0;
      grp_q  <= '0;
    end else if (clr_i) begin
      act_q  <= 1'b0;
      left_q <= '0;
      grp_q  <= '0;
    end else if (en_i && fall_i) begin
      act_q  <= 1'b1;
      grp_q  <= grp_nxt;
      sh_q   <= src << step_i;
      left_q <= left_base - {1'b0, step_i};
    end
  end

  always_comb begin
    sio_o    = '0;
    sio_oe_o = '0;
    if (act_q) begin
      unique case (step_i)
        3'd4: begin sio_o = grp_q;                     sio_oe_o = 4'b1111; end
        3'd2: begin sio_o = {2'b00, grp_q[1:0]};       sio_oe_o = 4'b0011; end
        default: begin sio_o = {2'b00, grp_q[0], 1'b0}; sio_oe_o = 4'b0010; end
      endcase
    end
  end

  a_r7_oe_lane_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sio_oe_o != 4'b0000) |->
      (sio_oe_o == 4'b0010 || sio_oe_o == 4'b0011 || sio_oe_o == 4'b1111));

endmodule

// File: rtl/ssram_byte_array.sv
module ssram_byte_array #(
  parameter int AW = 11
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);

  localparam int DEPTH = 1 << AW;

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/ssram_slave.sv
module ssram_slave
  import ssram_pkg::*;
#(
  parameter int MEM_AW = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sck_i,
  input  logic [3:0]        sio_i,
  output logic [3:0]        sio_o,
  output logic [3:0]        sio_oe_o,
  input  logic [1:0]        width_i,
  input  logic [MEM_AW-1:0] peek_addr_i,
  output logic [7:0]        peek_data_o
);

  logic              sck_rise, sck_fall;
  logic              byte_vld;
  logic [7:0]        byte_val;
  logic [1:0]        width_q;
  logic [2:0]        step;
  logic [7:0]        mode_byte;
  phase_e            phase_q;
  logic [MEM_AW-1:0] addr_q;
  logic [1:0]        addr_cnt_q;
  logic              mem_we;

  assign step      = lane_step(width_q);
  assign mode_byte = {MODE_SEQ, 4'b0000, width_q};
  assign mem_we    = byte_vld && (phase_q == ST_DATA) && !cs_ni;

  ssram_sck_edge i_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sck_i  (sck_i),
    .rise_o (sck_rise),
    .fall_o (sck_fall)
  );

  ssram_deser i_deser (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (cs_ni),
    .rise_i     (sck_rise),
    .step_i     (step),
    .sio_i      (sio_i),
    .byte_vld_o (byte_vld),
    .byte_o     (byte_val)
  );

  ssram_mode_tx i_tx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (cs_ni),
    .en_i     (phase_q == ST_MODE),
    .fall_i   (sck_fall),
    .step_i   (step),
    .mode_i   (mode_byte),
    .sio_o    (sio_o),
    .sio_oe_o (sio_oe_o)
  );

  ssram_byte_array #(.AW(MEM_AW)) i_array (
    .clk_i   (clk_i),
    .we_i    (mem_we),
    .waddr_i (addr_q),
    .wdata_i (byte_val),
    .raddr_i (peek_addr_i),
    .rdata_o (peek_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q    <= ST_CMD;
      addr_q     <= '0;
      addr_cnt_q <= '0;
      width_q    <= '0;
    end else if (cs_ni) begin
      phase_q    <= ST_CMD;
      addr_cnt_q <= '0;
      width_q    <= width_i;
    end else if (byte_vld) begin
      unique case (phase_q)
        ST_CMD: begin
          if (byte_val == OP_WRITE)       phase_q <= ST_ADDR;
          else if (byte_val == OP_RDMODE) phase_q <= ST_MODE;
          else                            phase_q <= ST_SKIP;
        end
        ST_ADDR: begin
          // only the array index bits are kept
          addr_q     <= MEM_AW'({addr_q, byte_val});
          addr_cnt_q <= addr_cnt_q + 2'd1;
          if (addr_cnt_q == 2'd2) phase_q <= ST_DATA;
        end
        ST_DATA: addr_q <= addr_q + 1'b1;
        default: ;
      endcase
    end
  end

  a_r1_quiet_after_deselect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> (sio_oe_o == 4'b0000));

  a_r8_hiz_outside_rdmode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q != ST_MODE) |-> (sio_oe_o == 4'b0000));

  a_r5_addr_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we |=> (addr_q == $past(addr_q) + 1'b1));

  a_r10_width_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && !$past(cs_ni)) |-> $stable(width_q));

  a_r11_skip_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == ST_SKIP) |-> !mem_we);

endmodule

// File: tb/test_ssram_slave.sv
module test_ssram_slave;

  localparam int CLK_PERIOD = 10;
  localparam int MEM_AW     = 8;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              cs_ni = 1'b1;
  logic              sck = 1'b0;
  logic [3:0]        sio_i = '0;
  logic [3:0]        sio_o, sio_oe_o;
  logic [1:0]        width_i = 2'b00;
  logic [MEM_AW-1:0] peek_addr = '0;
  logic [7:0]        peek_data;

  int n_checks = 0;
  int n_fails  = 0;
  logic [3:0] oe_seen;

  always #(CLK_PERIOD/2) clk = ~clk;

  ssram_slave #(.MEM_AW(MEM_AW)) i_ssram_slave (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .cs_ni       (cs_ni),
    .sck_i       (sck),
    .sio_i       (sio_i),
    .sio_o       (sio_o),
    .sio_oe_o    (sio_oe_o),
    .width_i     (width_i),
    .peek_addr_i (peek_addr),
    .peek_data_o (peek_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int step_of(input logic [1:0] w);
    return w[1] ? 4 : (w[0] ? 2 : 1);
  endfunction

  // one serial clock: drive d, sample outputs just before the rising edge
  task automatic sck_cycle(input logic [3:0] d, output logic [3:0] so, output logic [3:0] oe);
    @(negedge clk); sio_i = d;
    repeat (2) @(negedge clk);
    so = sio_o; oe = sio_oe_o;
    sck = 1'b1;
    repeat (4) @(negedge clk);
    sck = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_bits(input logic [7:0] b, input int step, input int nbits);
    logic [3:0] so, oe, d;
    for (int i = 0; i < nbits / step; i++) begin
      if (step == 4)      d = (i == 0) ? b[7:4] : b[3:0];
      else if (step == 2) d = {2'b00, b[7-2*i -: 2]};
      else                d = {3'b000, b[7-i]};
      sck_cycle(d, so, oe);
      oe_seen |= oe;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input int step);
    send_bits(b, step, 8);
  endtask

  task automatic select(input logic [1:0] w);
    @(negedge clk); width_i = w; cs_ni = 1'b1;
    repeat (3) @(negedge clk);
    cs_ni = 1'b0; oe_seen = '0;
    repeat (2) @(negedge clk);
  endtask

  task automatic deselect();
    repeat (2) @(negedge clk);
    cs_ni = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_addr(input logic [23:0] a, input int step);
    send_byte(a[23:16], step);
    send_byte(a[15:8], step);
    send_byte(a[7:0], step);
  endtask

  task automatic peek(input logic [MEM_AW-1:0] a, output logic [7:0] v);
    @(negedge clk); peek_addr = a;
    @(negedge clk); v = peek_data;
  endtask

  task automatic read_mode(input int step, output logic [7:0] v, output logic [3:0] oe_out);
    logic [3:0] so, oe;
    v = '0; oe_out = '1;
    for (int i = 0; i < 8 / step; i++) begin
      sck_cycle(4'b0000, so, oe);
      if (i == 0) oe_out = oe;
      else if (oe !== oe_out) oe_out = 4'bxxxx;
      if (step == 4)      v = {v[3:0], so};
      else if (step == 2) v = {v[5:0], so[1:0]};
      else                v = {v[6:0], so[1]};
    end
  endtask

  task automatic t_reset();
    chk("R1 oe during reset", sio_oe_o, 4'b0000);
  endtask

  task automatic t_write(input logic [1:0] w, input string req, input logic [23:0] a,
                         input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2);
    logic [7:0] v;
    int s = step_of(w);
    select(w);
    send_byte(8'h02, s);
    send_addr(a, s);
    send_byte(b0, s); send_byte(b1, s); send_byte(b2, s);
    chk({"R8 no drive in write ", req}, oe_seen, 4'b0000);
    deselect();
    peek(a[MEM_AW-1:0], v);                  chk({req, " byte0"}, v, b0);
    peek(a[MEM_AW-1:0] + 8'd1, v);           chk({req, " byte1"}, v, b1);
    peek(a[MEM_AW-1:0] + 8'd2, v);           chk({req, " byte2"}, v, b2);
  endtask

  task automatic t_wrap();
    logic [7:0] v;
    select(2'b10);
    send_byte(8'h02, 4);
    send_addr(24'hABCDFF, 4);
    send_byte(8'h5A, 4); send_byte(8'hA5, 4); send_byte(8'h3C, 4);
    deselect();
    peek(8'hFF, v); chk("R5 top location", v, 8'h5A);
    peek(8'h00, v); chk("R5 wrapped to 0", v, 8'hA5);
    peek(8'h01, v); chk("R5 after wrap", v, 8'h3C);
  endtask

  task automatic t_partial();
    logic [7:0] v;
    select(2'b10);
    send_byte(8'h02, 4); send_addr(24'h000040, 4);
    send_byte(8'h11, 4); send_byte(8'h22, 4);
    deselect();
    select(2'b10);
    send_byte(8'h02, 4); send_addr(24'h000041, 4);
    send_bits(8'hEE, 4, 4);
    deselect();
    peek(8'h41, v); chk("R6 quad half byte dropped", v, 8'h22);
    select(2'b00);
    send_byte(8'h02, 1); send_addr(24'h000040, 1);
    send_bits(8'hF0, 1, 5);
    deselect();
    peek(8'h40, v); chk("R6 single 5 bits dropped", v, 8'h11);
  endtask

  task automatic t_unknown();
    logic [7:0] v;
    select(2'b00);
    send_byte(8'h03, 1); send_addr(24'h000040, 1);
    send_byte(8'h99, 1); send_byte(8'h98, 1);
    chk("R11 unknown command not driven", oe_seen, 4'b0000);
    deselect();
    peek(8'h40, v); chk("R11 unknown command no write", v, 8'h11);
  endtask

  task automatic t_rdmode(input logic [1:0] w);
    logic [7:0] v;
    logic [3:0] oe, exp_oe;
    int s = step_of(w);
    exp_oe = (s == 4) ? 4'b1111 : (s == 2) ? 4'b0011 : 4'b0010;
    select(w);
    send_byte(8'h05, s);
    chk("R8 hi-z during command", oe_seen, 4'b0000);
    read_mode(s, v, oe);
    chk("R9 mode byte value", v, {2'b01, 4'b0000, w});
    chk("R7 output lanes", oe, exp_oe);
    deselect();
    chk("R1 oe after deselect", sio_oe_o, 4'b0000);
  endtask

  task automatic t_hold();
    logic [7:0] v;
    logic [3:0] oe;
    select(2'b00);
    send_byte(8'h05, 1);
    @(negedge clk); width_i = 2'b10;
    read_mode(1, v, oe);
    chk("R10 width held, mode byte", v, 8'h40);
    chk("R10 width held, lanes", oe, 4'b0010);
    deselect();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    t_write(2'b00, "R2 single", 24'h120010, 8'hC3, 8'h81, 8'h7E);
    t_write(2'b01, "R3 dual",   24'h000020, 8'hB4, 8'h69, 8'h0F);
    t_write(2'b10, "R4 quad",   24'hFF0030, 8'hD2, 8'h2D, 8'hE1);
    t_write(2'b11, "R4 quad code 11", 24'h000050, 8'h96, 8'h18, 8'hF7);
    t_wrap();
    t_partial();
    t_unknown();
    t_rdmode(2'b00);
    t_rdmode(2'b01);
    t_rdmode(2'b10);
    t_rdmode(2'b11);
    t_hold();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule